// File: doc/BRIEF.md
# Write-Only Regulator Control Slave

This block sits behind a two-wire serial bus (I2C) and lets a host processor switch two linear regulators and two high-side drivers on and off, and pick their output levels. The host writes a single control byte to a fixed 7-bit device address. There is no sub-address and no read-back. The byte is stored and decoded straight into enable and level-select outputs, which the analog side of the chip uses.

The bus lines are oversampled with a system clock that runs at least 16 times the SCL rate. The block detects START and STOP itself. It acknowledges its own write address and exactly one data byte by asserting an output-enable for the open-drain SDA pad.

Two conditions override the stored value. While the chip is in standby (the active-mode enable is low), the bus is ignored and the register is cleared. While battery over-voltage is flagged, every output is held low. The register value is kept during over-voltage, so the outputs return on their own when the flag drops.

Top module: `regctl_i2c_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) ends the transaction. Bits clocked after a STOP without a new START are not acknowledged and leave the outputs unchanged.
- R2: A START (SDA falling while SCL is high) followed by the address byte 0x10 (7-bit address 0001000, R/W bit 0 = write) is acknowledged. The block asserts `sda_oe` while SCL is low after the eighth bit and releases it after the ninth clock.
- R3: An address byte with a different 7-bit address is not acknowledged. Every byte after it is ignored until the next START.
- R4: An address byte 0x11 (own address with R/W = 1, read) is not acknowledged, and the data that follows has no effect.
- R5: The first data byte after an acknowledged address is received MSB first and acknowledged. It is stored in the same system clock in which the SCL rising edge of its eighth bit is seen after the two-stage synchroniser, which is three clocks after SCL rises at the pin.
- R6: Stored byte decode: bit 7 drives `ldo2_on`; bits 6:4 drive `ldo2_sel` (000=3.3 V, 001=5.0 V, 010=5.5 V, 011=6.0 V, 100=7.0 V, 101=7.5 V, 110=8.0 V, 111=10.0 V); bit 3 drives `ldo1_on`; bit 2 drives `ldo1_hi` (0=5 V, 1=8.5 V); bit 1 drives `drv2_on`; bit 0 drives `drv1_on`.
- R7: A second data byte in the same transaction is not acknowledged and does not change the stored value.
- R8: While `ovp_flag` is high, all decoded outputs are 0 in the same cycle. Writes are still accepted and stored. The stored value appears again as soon as `ovp_flag` drops.
- R9: While `active_en` is low, all decoded outputs are 0 and the bus is not acknowledged. The register is cleared to 0x00, so the outputs stay 0 after active mode returns, until a new write.
- R10: After reset, all decoded outputs and `sda_oe` are 0.
- R11: A repeated START, whether after a byte or part-way through one, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_en | input | 1 | High in active mode; low means standby |
| ovp_flag | input | 1 | Battery over-voltage flag; forces outputs off |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad (wired bus value) |
| sda_oe | output | 1 | Pulls SDA low when high (acknowledge) |
| ldo2_on | output | 1 | Enable for the high-current linear regulator |
| ldo2_sel | output | 3 | Level code for the high-current regulator |
| ldo1_on | output | 1 | Enable for the low-current linear regulator |
| ldo1_hi | output | 1 | Level select for the low-current regulator, 1 = 8.5 V |
| drv2_on | output | 1 | Enable for high-side driver 2 |
| drv1_on | output | 1 | Enable for high-side driver 1 |

## Verification
The bench builds the block with its default address of 0001000 and two synchroniser stages. It drives SCL with a half period of 16 system clocks, which is twice the minimum oversampling ratio. The synchroniser delay of three clocks is then fixed and known, so the reference model can set its expected register in the exact clock that the last data bit lands, and compare outputs every cycle. At this ratio, acknowledge timing, repeated STARTs part-way through a byte, and over-voltage or standby toggles between transactions are all exercised at the cycle level.

// File: rtl/regctl_i2c_slave.sv
module regctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_en,
  input  logic       ovp_flag,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       ldo2_on,
  output logic [2:0] ldo2_sel,
  output logic       ldo1_on,
  output logic       ldo1_hi,
  output logic       drv2_on,
  output logic       drv1_on
);
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [BYTE_BITS-1:0] WR_ADDR = {DEV_ADDR, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_SKIP} st_t;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic                   scl_d, sda_d;
  st_t                    st;
  logic [CNT_W-1:0]       cnt;
  logic [BYTE_BITS-2:0]   shreg;
  logic [BYTE_BITS-1:0]   ctrl_q;

  wire scl_s = scl_sr[SYNC_STAGES-1];
  wire sda_s = sda_sr[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_ev = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
  wire [BYTE_BITS-1:0] byte_nxt = {shreg, sda_s};
  wire gate = active_en & ~ovp_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      sda_oe <= 1'b0;
      ctrl_q <= '0;
    end else if (!active_en) begin
      st     <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      sda_oe <= 1'b0;
      ctrl_q <= '0;
    end else if (start_ev) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_DATA: if (scl_rise) begin
          shreg <= byte_nxt[BYTE_BITS-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            if (st == S_ADDR) st <= (byte_nxt == WR_ADDR) ? S_AACK : S_SKIP;
            else begin
              ctrl_q <= byte_nxt;
              st     <= S_DACK;
            end
          end
        end
        S_AACK, S_DACK: if (scl_fall) begin
          if (!sda_oe) sda_oe <= 1'b1;
          else begin
            sda_oe <= 1'b0;
            st     <= (st == S_AACK) ? S_DATA : S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign {ldo2_on, ldo2_sel, ldo1_on, ldo1_hi, drv2_on, drv1_on} =
         gate ? ctrl_q : '0;

  // R8
  ovp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_flag |-> !(ldo2_on || ldo1_on || ldo1_hi || drv2_on || drv1_on) && ldo2_sel == 3'd0);
  // R9
  stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_en |=> (ctrl_q == '0) && !sda_oe);
  // R2
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R3
  ack_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_AACK || st == S_DACK));
  // R5
  ctrl_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q != $past(ctrl_q)) && active_en && $past(active_en) |-> $past(st == S_DATA && scl_rise));
endmodule

// File: tb/test_regctl_i2c_slave.sv
module test_regctl_i2c_slave;
  localparam int HALF = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, active_en, ovp_flag, scl_m, sda_m;
  logic sda_oe, ldo2_on, ldo1_on, ldo1_hi, drv2_on, drv1_on;
  logic [2:0] ldo2_sel;
  wire sda_line = sda_m & ~sda_oe;

  regctl_i2c_slave i_regctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .active_en(active_en), .ovp_flag(ovp_flag),
    .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .ldo2_on(ldo2_on), .ldo2_sel(ldo2_sel), .ldo1_on(ldo1_on), .ldo1_hi(ldo1_hi),
    .drv2_on(drv2_on), .drv1_on(drv1_on));

  int tests = 0, fails = 0;
  string cur_req = "R10";
  logic [7:0] exp_ctrl = 8'h00, commit_val = 8'h00;
  int mstate = 0;
  bit mon_on = 0, finished = 0;
  bit ack_got;

  function automatic logic [7:0] got_out();
    return {ldo2_on, ldo2_sel, ldo1_on, ldo1_hi, drv2_on, drv1_on};
  endfunction
  function automatic logic [7:0] exp_out();
    return (active_en && !ovp_flag) ? exp_ctrl : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on && !finished) check(cur_req, got_out(), exp_out());
  end

  task automatic put_bit(input logic b, input bit commit);
    @(negedge clk) sda_m = b;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b1;
    if (commit) begin
      repeat (3) @(posedge clk);
      exp_ctrl = commit_val;
    end
    repeat (HALF) @(negedge clk);
    scl_m = 1'b0;
    repeat (HALF/2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    bit exp_ack, cm;
    cm = 0;
    case (mstate)
      1: begin exp_ack = (b == 8'h10); mstate = exp_ack ? 2 : 3; end
      2: begin exp_ack = 1; cm = 1; commit_val = b; mstate = 3; end
      default: exp_ack = 0;
    endcase
    for (int i = 7; i >= 0; i--) put_bit(b[i], cm && i == 0);
    @(negedge clk) sda_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    ack_got = ~sda_line;
    tests++;
    if (ack_got != exp_ack) begin
      fails++;
      $display("FAIL %s: ack got %0d expected %0d (byte %h)", req, ack_got, exp_ack, b);
    end
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0;
    repeat (HALF/2) @(negedge clk);
  endtask

  task automatic bus_start();
    @(negedge clk) sda_m = 1'b1;
    repeat (4) @(negedge clk);
    scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    sda_m = 1'b0;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b0;
    mstate = active_en ? 1 : 3;
    repeat (HALF/2) @(negedge clk);
  endtask

  task automatic bus_stop();
    @(negedge clk) sda_m = 1'b0;
    repeat (HALF/2) @(negedge clk);
    scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    sda_m = 1'b1;
    mstate = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic write_txn(input logic [7:0] a, input logic [7:0] d, input string req);
    cur_req = req;
    bus_start();
    send_byte(a, req);
    send_byte(d, req);
    bus_stop();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; active_en = 1; ovp_flag = 0; scl_m = 1; sda_m = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", got_out(), 8'h00);
    check("R10", {7'd0, sda_oe}, 8'h00);
    mon_on = 1;

    // R2 R5: basic write
    write_txn(8'h10, 8'hA5, "R5");
    check("R5", got_out(), 8'hA5);

    // R6: field decode 1_011_0_1_1_0
    write_txn(8'h10, 8'hB6, "R6");
    check("R6", {7'd0, ldo2_on}, 8'd1);
    check("R6", {5'd0, ldo2_sel}, 8'd3);
    check("R6", {7'd0, ldo1_on}, 8'd0);
    check("R6", {7'd0, ldo1_hi}, 8'd1);
    check("R6", {7'd0, drv2_on}, 8'd1);
    check("R6", {7'd0, drv1_on}, 8'd0);
    for (int k = 0; k < 8; k++) begin
      write_txn(8'h10, {1'b1, 3'(k), 4'b1001}, "R6");
      check("R6", {5'd0, ldo2_sel}, 8'(k));
    end
    write_txn(8'h10, 8'h00, "R6");
    write_txn(8'h10, 8'h4C, "R6");

    // R3: foreign address, then bytes ignored
    write_txn(8'h12, 8'hFF, "R3");
    write_txn(8'h20, 8'h01, "R3");
    check("R3", got_out(), 8'h4C);

    // R4: read request to own address
    write_txn(8'h11, 8'h33, "R4");
    check("R4", got_out(), 8'h4C);

    // R7: second data byte
    cur_req = "R7";
    bus_start();
    send_byte(8'h10, "R7");
    send_byte(8'h81, "R7");
    send_byte(8'h7E, "R7");
    bus_stop();
    check("R7", got_out(), 8'h81);

    // R1: bits after STOP without START
    cur_req = "R1";
    @(negedge clk) scl_m = 1'b0;
    repeat (HALF/2) @(negedge clk);
    send_byte(8'h10, "R1");
    send_byte(8'h55, "R1");
    bus_stop();
    check("R1", got_out(), 8'h81);

    // R11: repeated START after a byte and inside a byte
    cur_req = "R11";
    bus_start();
    send_byte(8'h22, "R11");
    bus_start();
    send_byte(8'h10, "R11");
    put_bit(1'b1, 0);
    put_bit(1'b1, 0);
    put_bit(1'b0, 0);
    bus_start();
    send_byte(8'h10, "R11");
    send_byte(8'h3C, "R11");
    bus_stop();
    check("R11", got_out(), 8'h3C);

    // R8: over-voltage gating and write during over-voltage
    cur_req = "R8";
    @(negedge clk) ovp_flag = 1;
    repeat (2) @(negedge clk);
    check("R8", got_out(), 8'h00);
    write_txn(8'h10, 8'hE7, "R8");
    check("R8", got_out(), 8'h00);
    @(negedge clk) ovp_flag = 0;
    repeat (2) @(negedge clk);
    check("R8", got_out(), 8'hE7);

    // R9: standby clears and ignores bus
    cur_req = "R9";
    @(negedge clk) begin active_en = 0; exp_ctrl = 8'h00; end
    repeat (2) @(negedge clk);
    check("R9", got_out(), 8'h00);
    write_txn(8'h10, 8'hFF, "R9");
    @(negedge clk) active_en = 1;
    repeat (4) @(negedge clk);
    check("R9", got_out(), 8'h00);
    write_txn(8'h10, 8'h5A, "R9");
    check("R9", got_out(), 8'h5A);

    repeat (10) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule